// File: doc/BRIEF.md
# Indexed Chipset Configuration Registers

This block gives a chipset a small configuration space reached through two I/O ports. Software writes a register index to the index port (22H). It then makes one access to the data port (23H). That access reads or writes the register the index names. Three registers are implemented, at indices 60H, 61H and 62H. From their bits the block drives:

- the processor-clock source select,
- the I/O command delay,
- two wait-state fields,
- a two-bit bus clocking mode code,
- a software CPU reset pulse.

An index can be used for one data-port access only. After that access the index is consumed, and software has to write the index port again before the next access, even when it is reaching the same register. While no valid index is held, data-port reads return FFH and data-port writes are dropped. Reads return FFH and writes are dropped in the same way when the index names no implemented register.

Top module: `cfg_index_regs`

## Requirements
- R1: After reset the registers hold 60H=00H, 61H=40H and 62H=00H. Also after reset, `bus_mode` is 00, `cpu_reset` is 0 and the data port holds no valid index.
- R2: A write to port 22H stores the index byte and makes it valid. A read of port 22H returns the stored index.
- R3: With a valid index of 60H, 61H or 62H, a read of port 23H returns that register and a write of port 23H loads it. The new value is visible on the outputs in the cycle after the write.
- R4: Any read or write of port 23H consumes the index. Until port 22H is written again, port 23H reads FFH and writes to it change nothing.
- R5: With a valid index other than 60H, 61H and 62H, a read of port 23H returns FFH and a write of port 23H changes no register or output.
- R6: Reserved bits always read 0, whatever value is written to them. The only writable bits are 60H bits 5 and 0, 61H bits 6, 3:0 and 62H bits 3:0.
- R7: `bus_mode` is 11 (external) whenever 62H bit 0 is 1. Otherwise:
  - if 62H bit 1 is 1, it is 01 (quick) when 61H bit 6 is 0 and 10 (delayed) when 61H bit 6 is 1;
  - if 62H bit 1 is 0, it is 00 (normal).
- R8: Writing 60H with bit 5 set raises `cpu_reset` in the next cycle. The pulse lasts exactly 16 cycles. 60H bit 5 reads 1 while the pulse runs and 0 once it has ended.
- R9: Writes to 60H during a pulse neither lengthen nor shorten it, whether bit 5 is 1 or 0. The other bits of 60H are still written.
- R10: `pclk_alt` follows 60H bit 0. `io_cmd_delay` follows 61H bits 1:0. `mem_ws8` follows 61H bits 3:2. `mem_ws16` follows 62H bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data for ports 22H and 23H, 00H otherwise |
| pclk_alt | output | 1 | Processor clock taken from the alternate clock |
| io_cmd_delay | output | 2 | I/O command delay field |
| mem_ws8 | output | 2 | 8-bit bus memory wait states |
| mem_ws16 | output | 2 | 16-bit bus memory wait states |
| bus_mode | output | 2 | 00 normal, 01 quick, 10 delayed, 11 external |
| cpu_reset | output | 1 | Software CPU reset pulse |

## Verification
The assertions check the following on every cycle:
- a data-port read directly after another data-port access returns FFH;
- the two reserved bits common to all three registers read zero;
- `bus_mode` moves only after a data-port write;
- each CPU reset pulse starts from a data write with bit 5 set and runs exactly 16 cycles.

Only the bench scenarios can show the rest:
- the per-register masks;
- the full mode table;
- that unmapped indices leave every register untouched;
- that writes during a pulse do not change its length.

The bench shows these by sweeping all 256 data values through each register and all 256 index values through the data port.

// File: rtl/cfg_index_regs.sv
module cfg_index_regs #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [7:0] BASE_IDX = 8'h60,
  parameter int RST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              pclk_alt,
  output logic [1:0]        io_cmd_delay,
  output logic [1:0]        mem_ws8,
  output logic [1:0]        mem_ws16,
  output logic [1:0]        bus_mode,
  output logic              cpu_reset
);
  localparam int CNT_W = $clog2(RST_LEN + 1);
  localparam logic [7:0] MASK_B = 8'h4F;
  localparam logic [7:0] MASK_C = 8'h0F;
  localparam logic [7:0] RST_B  = 8'h40;
  localparam logic [7:0] IDX_A  = BASE_IDX;
  localparam logic [7:0] IDX_B  = BASE_IDX + 8'd1;
  localparam logic [7:0] IDX_C  = BASE_IDX + 8'd2;

  logic [7:0]       idx_q;
  logic             idx_ok;
  logic             a_pclk;
  logic [7:0]       b_q, c_q;
  logic [CNT_W-1:0] rst_cnt;

  wire idx_wr = io_wr && io_addr == IDX_PORT;
  wire idx_rd = io_rd && io_addr == IDX_PORT;
  wire dat_wr = io_wr && io_addr == DAT_PORT;
  wire dat_rd = io_rd && io_addr == DAT_PORT;

  wire sel_a = idx_ok && idx_q == IDX_A;
  wire sel_b = idx_ok && idx_q == IDX_B;
  wire sel_c = idx_ok && idx_q == IDX_C;

  wire pulse_on = rst_cnt != '0;
  wire [7:0] a_view = {2'b00, pulse_on, 4'b0000, a_pclk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 8'h00;
      idx_ok <= 1'b0;
    end else if (idx_wr) begin
      idx_q  <= io_wdata;
      idx_ok <= 1'b1;
    end else if (dat_wr || dat_rd) begin
      idx_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pclk <= 1'b0;
      b_q    <= RST_B;
      c_q    <= 8'h00;
    end else if (dat_wr) begin
      if (sel_a) a_pclk <= io_wdata[0];
      if (sel_b) b_q <= io_wdata & MASK_B;
      if (sel_c) c_q <= io_wdata & MASK_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_cnt <= '0;
    else if (dat_wr && sel_a && io_wdata[5] && !pulse_on)
      rst_cnt <= CNT_W'(RST_LEN);
    else if (pulse_on)
      rst_cnt <= rst_cnt - 1'b1;
  end

  always_comb begin
    io_rdata = 8'h00;
    if (idx_rd)
      io_rdata = idx_q;
    else if (dat_rd)
      io_rdata = sel_a ? a_view : sel_b ? b_q : sel_c ? c_q : 8'hFF;
  end

  assign pclk_alt     = a_pclk;
  assign io_cmd_delay = b_q[1:0];
  assign mem_ws8      = b_q[3:2];
  assign mem_ws16     = c_q[3:2];
  assign cpu_reset    = pulse_on;
  assign bus_mode     = c_q[0] ? 2'b11 : c_q[1] ? (b_q[6] ? 2'b10 : 2'b01) : 2'b00;
endmodule

// File: rtl/cfg_index_regs_chk.sv
module cfg_index_regs_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter int RST_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              pclk_alt,
  input logic [1:0]        io_cmd_delay,
  input logic [1:0]        mem_ws8,
  input logic [1:0]        mem_ws16,
  input logic [1:0]        bus_mode,
  input logic              cpu_reset
);
  logic [7:0] hi_cnt;
  wire d_wr = io_wr && io_addr == DAT_PORT;
  wire d_rd = io_rd && io_addr == DAT_PORT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= 8'd0;
    else if (cpu_reset) hi_cnt <= hi_cnt + 8'd1;
    else hi_cnt <= 8'd0;

  a_r4_index_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(d_wr || d_rd) && d_rd |-> io_rdata == 8'hFF);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd && io_rdata != 8'hFF |-> io_rdata[7] == 1'b0 && io_rdata[4] == 1'b0);

  a_r7_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(d_wr) |-> $stable(bus_mode));

  a_r8_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset) |-> $past(d_wr && io_wdata[5]));

  a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> hi_cnt < 8'(RST_LEN));

  a_r9_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> hi_cnt == 8'(RST_LEN));
endmodule

bind cfg_index_regs cfg_index_regs_chk u_chk (.*);

// File: tb/cfg_index_regs_test.sv
module cfg_index_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0] io_wdata = 8'h0, io_rdata;
  logic pclk_alt, cpu_reset;
  logic [1:0] io_cmd_delay, mem_ws8, mem_ws16, bus_mode;
  int checks = 0, errors = 0, run = 0, last_run = 0, cyc = 0;
  logic [7:0] b_m = 8'h40, c_m = 8'h00, a_m = 8'h00;

  always #2 clk = ~clk;

  cfg_index_regs uut (.*);

  always @(negedge clk) begin
    if (cpu_reset) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  function automatic logic [1:0] mode_of(logic [7:0] b, logic [7:0] c);
    if (c[0]) return 2'b11;
    if (c[1]) return b[6] ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  task automatic outs_chk();
    chk("R7", {6'd0, bus_mode}, {6'd0, mode_of(b_m, c_m)});
    chk("R10", {2'd0, mem_ws16, mem_ws8, io_cmd_delay},
        {2'd0, c_m[3:2], b_m[3:2], b_m[1:0]});
    chk("R10", {7'd0, pclk_alt}, {7'd0, a_m[0]});
  endtask

  task automatic rdreg(logic [7:0] idx, string req, logic [7:0] exp);
    logic [7:0] d;
    wr(16'h22, idx);
    rd(16'h23, d);
    chk(req, d, exp);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {5'd0, bus_mode, cpu_reset}, 8'h00);
    rd(16'h23, d); chk("R1", d, 8'hFF);
    rdreg(8'h60, "R1", 8'h00);
    rdreg(8'h61, "R1", 8'h40);
    rdreg(8'h62, "R1", 8'h00);
    outs_chk();
    // R2 index readback
    wr(16'h22, 8'hA5); rd(16'h22, d); chk("R2", d, 8'hA5);
    // R3 R6 R10 sweep of 60H (bit 5 left clear)
    for (int v = 0; v < 256; v++) begin
      wr(16'h22, 8'h60); wr(16'h23, 8'(v) & 8'hDF);
      a_m = 8'(v) & 8'h01;
      rdreg(8'h60, "R6", a_m);
      outs_chk();
    end
    // R3 R6 R7 sweep of 62H with 61H fixed
    for (int v = 0; v < 256; v++) begin
      wr(16'h22, 8'h62); wr(16'h23, 8'(v));
      c_m = 8'(v) & 8'h0F;
      rdreg(8'h62, "R3", c_m);
      outs_chk();
    end
    wr(16'h22, 8'h62); wr(16'h23, 8'h02); c_m = 8'h02;
    // R3 R6 R7 sweep of 61H with quick/delayed selection active
    for (int v = 0; v < 256; v++) begin
      wr(16'h22, 8'h61); wr(16'h23, 8'(v));
      b_m = 8'(v) & 8'h4F;
      rdreg(8'h61, "R6", b_m);
      outs_chk();
    end
    // R4 index is single-use
    wr(16'h22, 8'h61); rd(16'h23, d); chk("R4", d, b_m);
    rd(16'h23, d); chk("R4", d, 8'hFF);
    wr(16'h23, b_m ^ 8'h0F);
    rdreg(8'h61, "R4", b_m);
    wr(16'h22, 8'h62); wr(16'h23, 8'h01); c_m = 8'h01;
    wr(16'h23, 8'h00);
    rdreg(8'h62, "R4", 8'h01);
    outs_chk();
    // R5 unmapped indices
    for (int i = 0; i < 256; i++) begin
      if (i >= 8'h60 && i <= 8'h62) continue;
      wr(16'h22, 8'(i)); rd(16'h23, d); chk("R5", d, 8'hFF);
      wr(16'h22, 8'(i)); wr(16'h23, 8'h2A);
    end
    rdreg(8'h60, "R5", a_m);
    rdreg(8'h61, "R5", b_m);
    rdreg(8'h62, "R5", c_m);
    outs_chk();
    chk("R5", {7'd0, cpu_reset}, 8'h00);
    // R8 reset pulse and bit 5 readback
    wr(16'h22, 8'h60); wr(16'h23, 8'h21); a_m = 8'h01;
    chk("R8", {7'd0, cpu_reset}, 8'h01);
    rdreg(8'h60, "R8", 8'h21);
    repeat (20) @(negedge clk);
    chk("R8", 8'(last_run), 8'd16);
    rdreg(8'h60, "R8", 8'h01);
    outs_chk();
    // R9 writes during a pulse
    wr(16'h22, 8'h60); wr(16'h23, 8'h20);
    wr(16'h22, 8'h60); wr(16'h23, 8'h01);
    wr(16'h22, 8'h60); wr(16'h23, 8'h20);
    wr(16'h22, 8'h60); wr(16'h23, 8'h21); a_m = 8'h01;
    chk("R9", {7'd0, cpu_reset}, 8'h01);
    repeat (20) @(negedge clk);
    chk("R9", 8'(last_run), 8'd16);
    rdreg(8'h60, "R9", 8'h01);
    outs_chk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule